// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block lets an outside master borrow a local memory interface. The outside master asks for the bus by pulling an active-low request line low. The controller waits until any local transaction that is already in progress has finished. It then stops driving every bus pin, counts a programmable settling delay, and pulls its active-low acknowledge low. From that point the outside master owns the bus.

When the request goes high again, the controller drives the bus again at once. It counts a second programmable delay and only then releases the acknowledge. While the controller is not idle, new local transaction requests are held off with a busy flag. They are stalled, not dropped. Two configuration inputs shape the behaviour:
- A block input refuses new grants for as long as it stays set.
- A clock-float input selects whether the bus clock output is tri-stated together with the bus group or keeps toggling.

The request pin is asynchronous, so it passes through a synchronizer before the state machine sees it. The bus output enable covers the whole bus group: chip selects, byte enables, address, data, the read, write and output-enable strobes, and the clock-enable and data-direction outputs. A single enable drives all of them.

Top module: `bus_hold_ctrl`

## Requirements
- R1: In the cycle after synchronous reset is released, hold_ack_n is 1, bus_oe is 1, clk_oe is 1 and loc_busy is 0.
- R2: The request passes through two synchronizer flops. Suppose hold_req_n is first low at a rising edge, with no block set. Then loc_busy first reads 1 after the third rising edge, counting that one.
- R3: While loc_active is 1, a synchronized request keeps the controller waiting. During the wait, bus_oe stays 1 and hold_ack_n stays 1. bus_oe falls one cycle after loc_active is seen at 0.
- R4: hold_ack_n falls only after bus_oe has been 0 for exactly clamp(cfg_float_dly) cycles. Here clamp maps values below 2 to 2 and values above 7 to 7, on a 4-bit field.
- R5: The release can happen no earlier than the second cycle of the grant. Once the synchronized request is seen high, bus_oe returns to 1. hold_ack_n stays 0 for exactly clamp(cfg_drive_dly) further cycles, with bus_oe at 1, and then returns to 1.
- R6: While cfg_block_hold is 1, a request in the idle or waiting state is ignored. The controller returns to or stays idle, with hold_ack_n at 1 and bus_oe at 1. A block applied after the grant has no effect on it.
- R7: If the request returns high while the controller is still waiting on a local transaction, the controller goes back to idle. bus_oe does not fall.
- R8: clk_oe is 0 exactly when cfg_clk_float is 1 and bus_oe is 0. Otherwise clk_oe is 1.
- R9: loc_busy is 1 in every non-idle state. loc_start equals loc_req while idle and is 0 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_n | input | 1 | Asynchronous active-low hold request from outside master |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| cfg_block_hold | input | 1 | 1 refuses new hold grants |
| cfg_clk_float | input | 1 | 1 tri-states the bus clock while the bus floats |
| cfg_float_dly | input | 4 | Float-to-acknowledge delay in cycles, clamped to 2..7 |
| cfg_drive_dly | input | 4 | Drive-to-release delay in cycles, clamped to 2..7 |
| loc_req | input | 1 | Local engine wants to start a transaction |
| loc_active | input | 1 | Local transaction pending or in progress |
| loc_start | output | 1 | Local transaction may launch this cycle |
| loc_busy | output | 1 | Local requests stalled |
| bus_oe | output | 1 | Output enable for the whole bus group |
| clk_oe | output | 1 | Output enable for the bus clock |

## Verification
The assertions assume that reset is held for at least one edge before use. They also assume that the outside master obeys the handshake. The float-window check further assumes that bus_oe only falls through the normal float path, which holds for any input sequence the ports allow. The bench changes every input only at falling edges, well away from the sampling edge. It also keeps the request low until at least one cycle after the acknowledge falls, so the synchronizer never sees a marginal input. Scenarios cover several delay settings (including both clamp limits), a busy local engine, a block and its removal, withdrawal during the wait, and a release on the first permitted cycle.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;

    localparam int CFG_DLY_W = 4;
    localparam int DLY_MIN   = 2;
    localparam int DLY_MAX   = 7;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_FLOAT = 3'd2,
        ST_GRANT = 3'd3,
        ST_DRIVE = 3'd4
    } hold_st_e;

    typedef struct packed {
        logic ack_n;
        logic bus_oe;
        logic clk_oe;
        logic busy;
    } hold_out_t;

    function automatic logic [CFG_DLY_W-1:0] clamp_dly(input logic [CFG_DLY_W-1:0] v);
        if (v < CFG_DLY_W'(DLY_MIN)) return CFG_DLY_W'(DLY_MIN);
        if (v > CFG_DLY_W'(DLY_MAX)) return CFG_DLY_W'(DLY_MAX);
        return v;
    endfunction

endpackage

// File: rtl/bh_sync.sv
module bh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bh_fsm.sv
module bh_fsm
    import bus_hold_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold_rq,
    input  logic                 block,
    input  logic                 loc_active,
    input  logic [CFG_DLY_W-1:0] float_dly,
    input  logic [CFG_DLY_W-1:0] drive_dly,
    output hold_st_e             state
);
    hold_st_e             st_q, st_d;
    logic [CFG_DLY_W-1:0] cnt_q, cnt_d;
    logic                 settled_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (hold_rq && !block) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!hold_rq || block) begin
                    st_d = ST_IDLE;
                end else if (!loc_active) begin
                    st_d  = ST_FLOAT;
                    cnt_d = clamp_dly(float_dly) - CFG_DLY_W'(1);
                end
            end
            ST_FLOAT: begin
                if (cnt_q == '0) st_d = ST_GRANT;
                else             cnt_d = cnt_q - CFG_DLY_W'(1);
            end
            ST_GRANT: begin
                if (settled_q && !hold_rq) begin
                    st_d  = ST_DRIVE;
                    cnt_d = clamp_dly(drive_dly) - CFG_DLY_W'(1);
                end
            end
            ST_DRIVE: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - CFG_DLY_W'(1);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            settled_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            settled_q <= (st_q == ST_GRANT);
        end
    end

    assign state = st_q;
endmodule

// File: rtl/bh_gate.sv
module bh_gate
    import bus_hold_pkg::*;
(
    input  hold_st_e  state,
    input  logic      clk_float,
    input  logic      loc_req,
    output hold_out_t outs,
    output logic      loc_start
);
    logic floated;
    logic owned;

    always_comb begin
        floated      = (state == ST_FLOAT) || (state == ST_GRANT);
        owned        = (state == ST_GRANT) || (state == ST_DRIVE);
        outs.ack_n   = !owned;
        outs.bus_oe  = !floated;
        outs.clk_oe  = !(floated && clk_float);
        outs.busy    = (state != ST_IDLE);
        loc_start    = loc_req && (state == ST_IDLE);
    end
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
    import bus_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold_req_n,
    output logic                 hold_ack_n,
    input  logic                 cfg_block_hold,
    input  logic                 cfg_clk_float,
    input  logic [CFG_DLY_W-1:0] cfg_float_dly,
    input  logic [CFG_DLY_W-1:0] cfg_drive_dly,
    input  logic                 loc_req,
    input  logic                 loc_active,
    output logic                 loc_start,
    output logic                 loc_busy,
    output logic                 bus_oe,
    output logic                 clk_oe
);
    logic      hold_rq;
    hold_st_e  state;
    hold_out_t outs;

    bh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (!hold_req_n),
        .q_sync  (hold_rq)
    );

    bh_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .hold_rq    (hold_rq),
        .block      (cfg_block_hold),
        .loc_active (loc_active),
        .float_dly  (cfg_float_dly),
        .drive_dly  (cfg_drive_dly),
        .state      (state)
    );

    bh_gate u_gate (
        .state     (state),
        .clk_float (cfg_clk_float),
        .loc_req   (loc_req),
        .outs      (outs),
        .loc_start (loc_start)
    );

    assign hold_ack_n = outs.ack_n;
    assign bus_oe     = outs.bus_oe;
    assign clk_oe     = outs.clk_oe;
    assign loc_busy   = outs.busy;
endmodule

// File: rtl/bus_hold_chk.sv
module bus_hold_chk
    import bus_hold_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic hold_ack_n,
    input logic bus_oe,
    input logic clk_oe,
    input logic loc_busy,
    input logic loc_start
);
    logic [3:0] float_cnt;

    always_ff @(posedge clk) begin
        if (rst)                          float_cnt <= '0;
        else if (bus_oe)                  float_cnt <= '0;
        else if (hold_ack_n && float_cnt != 4'hF) float_cnt <= float_cnt + 4'd1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hold_ack_n && bus_oe && clk_oe && !loc_busy));

    p_float_window_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> (!bus_oe && float_cnt >= 4'(DLY_MIN) && float_cnt <= 4'(DLY_MAX)));

    p_drive_before_release_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_n) |-> bus_oe);

    p_clk_follows_bus_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_oe |-> !bus_oe);

    p_no_start_when_busy_r9: assert property (@(posedge clk) disable iff (rst)
        loc_busy |-> !loc_start);

    p_busy_while_owned_r9: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_n |-> loc_busy);
endmodule

bind bus_hold_ctrl bus_hold_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold_ack_n (hold_ack_n),
    .bus_oe     (bus_oe),
    .clk_oe     (clk_oe),
    .loc_busy   (loc_busy),
    .loc_start  (loc_start)
);

// File: tb/bus_hold_ctrl_bench.sv
`timescale 1ns/1ps
module bus_hold_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_n = 1'b1;
    logic       blk = 1'b0;
    logic       cf = 1'b0;
    logic [3:0] fd = 4'd3;
    logic [3:0] dd = 4'd3;
    logic       lreq = 1'b0;
    logic       lact = 1'b0;
    logic       ack_n, oe, coe, busy, start;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_hold_ctrl u_bus_hold_ctrl (
        .clk(clk), .rst(rst), .hold_req_n(req_n), .hold_ack_n(ack_n),
        .cfg_block_hold(blk), .cfg_clk_float(cf),
        .cfg_float_dly(fd), .cfg_drive_dly(dd),
        .loc_req(lreq), .loc_active(lact), .loc_start(start),
        .loc_busy(busy), .bus_oe(oe), .clk_oe(coe)
    );

    // behavioural reference: phase 0 idle,1 wait,2 float,3 granted,4 drive
    int m_ph = 0, m_left = 0, m_gcyc = 0;
    bit m_s1 = 0, m_s2 = 0;
    logic s_ack, s_oe, s_busy;

    function automatic int clampv(input int v);
        if (v < 2) return 2;
        if (v > 7) return 7;
        return v;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic model_edge();
        bit rq;
        rq = m_s2;
        if (rst) begin
            m_ph = 0; m_left = 0; m_gcyc = 0; m_s1 = 0; m_s2 = 0;
            return;
        end
        case (m_ph)
            0: if (rq && !blk) m_ph = 1;
            1: if (!rq || blk) m_ph = 0;
               else if (!lact) begin m_ph = 2; m_left = clampv(int'(fd)); end
            2: begin m_left--; if (m_left == 0) begin m_ph = 3; m_gcyc = 0; end end
            3: begin
                if (m_gcyc >= 1 && !rq) begin m_ph = 4; m_left = clampv(int'(dd)); end
                else m_gcyc++;
               end
            4: begin m_left--; if (m_left == 0) m_ph = 0; end
            default: m_ph = 0;
        endcase
        m_s2 = m_s1;
        m_s1 = !req_n;
    endtask

    task automatic step();
        bit fl;
        #1;
        s_ack = ack_n; s_oe = oe; s_busy = busy;
        if (!rst) begin
            fl = (m_ph == 2 || m_ph == 3);
            cmp("R4 hold_ack_n", int'(ack_n), (m_ph == 3 || m_ph == 4) ? 0 : 1);
            cmp("R3 bus_oe", int'(oe), fl ? 0 : 1);
            cmp("R8 clk_oe", int'(coe), (fl && cf) ? 0 : 1);
            cmp("R9 loc_busy", int'(busy), (m_ph != 0) ? 1 : 0);
            cmp("R9 loc_start", int'(start), (lreq && m_ph == 0) ? 1 : 0);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // counts cycles with bus floated and ack high until ack falls
    task automatic to_grant(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            step();
            if (s_oe == 0 && s_ack == 1) n++;
            if (s_ack == 0) break;
        end
    endtask

    // counts cycles with bus driven and ack low until ack rises
    task automatic to_release(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            step();
            if (s_oe == 1 && s_ack == 0) n++;
            if (s_ack == 1) break;
        end
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int n;
        bit fell;
        @(negedge clk);
        run(3);
        rst = 1'b0;
        step();
        // R1 reset state
        cmp("R1 ack_n", int'(s_ack), 1);
        cmp("R1 bus_oe", int'(s_oe), 1);
        cmp("R1 loc_busy", int'(s_busy), 0);

        // R9 local starts pass through while idle
        lreq = 1'b1; run(3); lreq = 1'b0; run(2);

        // R2 synchronizer latency, then R4/R5 with idle bus
        fd = 4'd3; dd = 4'd4; cf = 1'b0;
        req_n = 1'b0;
        step(); cmp("R2 busy after 1 edge", int'(busy), 0);
        step(); cmp("R2 busy after 2 edges", int'(busy), 0);
        step(); cmp("R2 busy after 3 edges", int'(busy), 1);
        lreq = 1'b1;
        to_grant(n); cmp("R4 float delay 3", n, 3);
        run(4);
        blk = 1'b1; run(2);
        cmp("R6 block after grant no effect", int'(s_ack), 0);
        blk = 1'b0;
        req_n = 1'b1;
        to_release(n); cmp("R5 drive delay 4", n, 4);
        lreq = 1'b0; run(3);

        // R3 busy local engine, clamp low, clock float
        fd = 4'd0; dd = 4'd12; cf = 1'b1; lact = 1'b1;
        req_n = 1'b0;
        run(8);
        cmp("R3 bus kept during pending", int'(s_oe), 1);
        cmp("R3 ack kept during pending", int'(s_ack), 1);
        lact = 1'b0;
        to_grant(n); cmp("R4 float delay clamp low", n, 2);
        run(3);
        cmp("R8 clock floated", int'(coe), 0);
        req_n = 1'b1;
        to_release(n); cmp("R5 drive delay clamp high", n, 7);
        run(3);

        // R6 block refuses grant
        cf = 1'b0; blk = 1'b1; fd = 4'd9; dd = 4'd1;
        req_n = 1'b0;
        run(12);
        cmp("R6 ack held off", int'(s_ack), 1);
        cmp("R6 bus still driven", int'(s_oe), 1);
        cmp("R6 idle while blocked", int'(s_busy), 0);
        blk = 1'b0;
        to_grant(n); cmp("R4 float delay clamp high", n, 7);
        req_n = 1'b1;
        to_release(n); cmp("R5 drive delay clamp low", n, 2);
        run(3);

        // R7 withdrawal during wait
        lact = 1'b1; fd = 4'd4; dd = 4'd3;
        req_n = 1'b0;
        fell = 0;
        for (int i = 0; i < 6; i++) begin step(); if (s_oe == 0) fell = 1; end
        cmp("R7 waiting busy", int'(s_busy), 1);
        req_n = 1'b1;
        for (int i = 0; i < 6; i++) begin step(); if (s_oe == 0) fell = 1; end
        cmp("R7 bus never floated", int'(fell), 0);
        cmp("R7 back to idle", int'(s_busy), 0);
        lact = 1'b0; run(2);

        // R5 earliest release: request dropped as soon as ack falls
        req_n = 1'b0;
        to_grant(n); cmp("R4 float delay 4", n, 4);
        req_n = 1'b1;
        to_release(n); cmp("R5 drive delay 3 after short grant", n, 3);
        run(4);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule